// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Dual-Strobe Clear

This block counts ticks from one of two selectable enable sources and raises a reset when software fails to service it in time. A fixed binary base divider feeds a prescaler whose ratio, a power of two from 1:1 to 1:128, comes from the low three bits of an 8-bit control register. The upper five bits of that register are plain storage for software flags. Clocks are modeled as single-cycle enable pulses on the one system clock.

The count is restarted by an active-low external reset, by a HALT-entry strobe, or by software clear strobes. A configuration input selects how software clears it. In single mode one dedicated strobe is enough. In dual mode two distinct strobes, A and B, must both be seen, in either order or together. When the count runs out the block emits a one-cycle chip-reset pulse while the core runs, or a one-cycle warm-reset pulse while the core is halted. In both cases it sets a time-out flag. The warm reset is meant to restart only the program counter and stack pointer.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is released, `chip_rst_o`, `warm_rst_o` and `to_flag_o` are 0, and `reg_rdata` reads 0, which selects ratio 1:1.
- R2: With a tick in every cycle, the overflow falls on the (2^BASE_STAGES × 2^sel)-th tick after the last restart. Here sel is `reg_rdata[2:0]`: 000 gives ×1 and 111 gives ×128. With the default BASE_STAGES=8 this is 256, 2048 or 32768 ticks for sel 0, 3 or 7.
- R3: A write with `reg_wr`=1 stores `reg_wdata`, and it reads back on `reg_rdata` in the next cycle. Bits 7:3 do not change the time-out.
- R4: `src_sel`=1 counts `osc_tick`, including while `halted`=1. `src_sel`=0 counts `instr_tick` only while `halted`=0.
- R5: A `halt_enter` strobe restarts the base divider and the prescaler from zero. It also clears `to_flag_o`.
- R6: With `dual_clr_mode`=0, a `clr_single` strobe restarts the count. `clr_a` and `clr_b` have no effect in this mode.
- R7: With `dual_clr_mode`=1, the count restarts once both `clr_a` and `clr_b` have been seen, in either order or in the same cycle. Repeating one strobe does not complete the pair, and `clr_single` has no effect in this mode.
- R8: In dual mode, a half-completed pair is discarded whenever the count restarts for any other reason (a HALT entry or an overflow).
- R9: An overflow while `halted`=0 gives `chip_rst_o` for exactly one cycle, in the cycle after the overflowing tick. It also sets `to_flag_o`.
- R10: An overflow while `halted`=1 gives `warm_rst_o` for exactly one cycle, sets `to_flag_o`, and leaves `chip_rst_o` low.
- R11: After an overflow the count restarts from zero, so the next overflow needs another full period.
- R12: A clear in the same cycle as the overflowing tick takes priority. No reset pulse is issued and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| osc_tick | input | 1 | Dedicated watchdog oscillator tick |
| instr_tick | input | 1 | Instruction clock tick |
| src_sel | input | 1 | 1: count osc_tick, 0: count instr_tick |
| halted | input | 1 | Core is in HALT |
| halt_enter | input | 1 | Strobe: core enters HALT |
| dual_clr_mode | input | 1 | 0: single-strobe clear, 1: two-strobe clear |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_a | input | 1 | Dual-mode clear strobe A |
| clr_b | input | 1 | Dual-mode clear strobe B |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| chip_rst_o | output | 1 | Full chip reset pulse |
| warm_rst_o | output | 1 | Warm reset pulse (core halted) |
| to_flag_o | output | 1 | Time-out flag |

## Verification
The output registers take the overflow on the very edge of the N-th tick after a restart. A reset pulse is therefore visible one edge after the last tick, and a register write reads back one edge after the write. Every restart strobe acts on the edge that samples it. The bench drives and samples on the falling edge. It counts ticks exactly and checks that there is no pulse after N−1 ticks, a pulse after N ticks, and no pulse one cycle later. Each "no effect" case is shown by the overflow still arriving at the tick count it would have had without the ignored strobe.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W  = 3;
  localparam int USER_W = 5;
  localparam int REG_W  = SEL_W + USER_W;

  typedef enum logic {
    CLR_MODE_SINGLE = 1'b0,
    CLR_MODE_DUAL   = 1'b1
  } clr_mode_e;

  typedef struct packed {
    logic [USER_W-1:0] user;
    logic [SEL_W-1:0]  sel;
  } ctrl_reg_t;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel (
  input  logic osc_tick,
  input  logic instr_tick,
  input  logic src_sel,
  input  logic halted,
  output logic tick
);
  always_comb begin
    if (src_sel) tick = osc_tick;
    else         tick = instr_tick & ~halted;
  end
endmodule

// File: rtl/wdog_clear_ctrl.sv
module wdog_clear_ctrl
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clr_mode_e mode,
  input  logic      halt_enter,
  input  logic      clr_single,
  input  logic      clr_a,
  input  logic      clr_b,
  input  logic      ovf,
  output logic      clear
);
  logic seen_a_q, seen_b_q;
  logic pair_done, sw_clear;

  always_comb begin
    pair_done = (clr_a | seen_a_q) & (clr_b | seen_b_q);
    sw_clear  = (mode == CLR_MODE_SINGLE) ? clr_single : pair_done;
    clear     = halt_enter | sw_clear;
  end

  // Pending half of a pair is dropped on any restart, or outside dual mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (clear || ovf || mode == CLR_MODE_SINGLE) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= seen_a_q | clr_a;
      seen_b_q <= seen_b_q | clr_b;
    end
  end
endmodule

// File: rtl/wdog_divchain.sv
module wdog_divchain #(
  parameter int BASE_STAGES = 8,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int PSC_W = (1 << SEL_W) - 1;

  logic [BASE_STAGES-1:0] base_q;
  logic [PSC_W-1:0]       psc_q;
  logic [PSC_W-1:0]       psc_mask;
  logic                   base_carry, psc_hit;

  // Thermometer mask: the prescaler stages in use for this ratio
  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign psc_mask[i] = (int'(sel) > i);
  end

  always_comb begin
    base_carry = &base_q;
    psc_hit    = ((psc_q & psc_mask) == psc_mask);
    ovf        = tick & base_carry & psc_hit & ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (clear) begin
      base_q <= '0;
    end else if (tick) begin
      base_q <= base_q + BASE_STAGES'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else if (clear || ovf) begin
      psc_q <= '0;
    end else if (tick && base_carry) begin
      psc_q <= psc_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_STAGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             instr_tick,
  input  logic             src_sel,
  input  logic             halted,
  input  logic             halt_enter,
  input  logic             dual_clr_mode,
  input  logic             clr_single,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             chip_rst_o,
  output logic             warm_rst_o,
  output logic             to_flag_o
);
  ctrl_reg_t ctrl_q;
  logic      tick, clear, ovf;
  clr_mode_e mode;

  assign mode      = clr_mode_e'(dual_clr_mode);
  assign reg_rdata = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (reg_wr) ctrl_q <= ctrl_reg_t'(reg_wdata);
  end

  wdog_tick_sel u_tick (
    .osc_tick   (osc_tick),
    .instr_tick (instr_tick),
    .src_sel    (src_sel),
    .halted     (halted),
    .tick       (tick)
  );

  wdog_clear_ctrl u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .halt_enter (halt_enter),
    .clr_single (clr_single),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .ovf        (ovf),
    .clear      (clear)
  );

  wdog_divchain #(
    .BASE_STAGES (BASE_STAGES),
    .SEL_W       (SEL_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clear (clear),
    .sel   (ctrl_q.sel),
    .ovf   (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_rst_o <= 1'b0;
      warm_rst_o <= 1'b0;
      to_flag_o  <= 1'b0;
    end else begin
      chip_rst_o <= ovf & ~halted;
      warm_rst_o <= ovf & halted;
      if (ovf)             to_flag_o <= 1'b1;
      else if (halt_enter) to_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic       instr_tick,
  input logic       src_sel,
  input logic       halted,
  input logic       halt_enter,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       chip_rst_o,
  input logic       warm_rst_o,
  input logic       to_flag_o
);
  a_r9_chip_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_o |=> !chip_rst_o);

  a_r10_warm_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |=> !warm_rst_o);

  a_r10_resets_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_rst_o && warm_rst_o));

  a_r10_warm_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> $past(halted));

  a_r9_chip_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_o |-> !$past(halted));

  a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst_o || warm_rst_o) |-> to_flag_o);

  a_r12_halt_entry_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> (!chip_rst_o && !warm_rst_o));

  a_r4_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst_o || warm_rst_o) |->
      $past(src_sel ? osc_tick : (instr_tick && !halted)));

  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_tick   (osc_tick),
  .instr_tick (instr_tick),
  .src_sel    (src_sel),
  .halted     (halted),
  .halt_enter (halt_enter),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .chip_rst_o (chip_rst_o),
  .warm_rst_o (warm_rst_o),
  .to_flag_o  (to_flag_o)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int BASE = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0, instr_tick = 1'b0, src_sel = 1'b1;
  logic       halted = 1'b0, halt_enter = 1'b0, dual_clr_mode = 1'b0;
  logic       clr_single = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       chip_rst_o, warm_rst_o, to_flag_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .instr_tick(instr_tick),
    .src_sel(src_sel), .halted(halted), .halt_enter(halt_enter),
    .dual_clr_mode(dual_clr_mode), .clr_single(clr_single), .clr_a(clr_a),
    .clr_b(clr_b), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chip_rst_o(chip_rst_o), .warm_rst_o(warm_rst_o),
    .to_flag_o(to_flag_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_for(int n);
    if (n > 0) begin
      osc_tick = 1'b1; instr_tick = 1'b1;
      repeat (n) @(negedge clk);
      osc_tick = 1'b0; instr_tick = 1'b0;
    end
  endtask

  // which: 0 single, 1 a, 2 b, 3 a+b together, 4 halt entry
  task automatic strobe(int which);
    case (which)
      0: clr_single = 1'b1;
      1: clr_a = 1'b1;
      2: clr_b = 1'b1;
      3: begin clr_a = 1'b1; clr_b = 1'b1; end
      default: halt_enter = 1'b1;
    endcase
    @(negedge clk);
    clr_single = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt_enter = 1'b0;
  endtask

  task automatic write_reg(logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R3 readback", reg_rdata, v);
  endtask

  task automatic expect_fire(string req, int n, bit warm);
    tick_for(n - 1);
    check({req, " early chip"}, chip_rst_o, 0);
    check({req, " early warm"}, warm_rst_o, 0);
    tick_for(1);
    check({req, " chip pulse"}, chip_rst_o, warm ? 0 : 1);
    check({req, " warm pulse"}, warm_rst_o, warm ? 1 : 0);
    check({req, " to flag"}, to_flag_o, 1);
    @(negedge clk);
    check({req, " one cycle"}, chip_rst_o | warm_rst_o, 0);
  endtask

  task automatic t_reset;
    check("R1 chip", chip_rst_o, 0);
    check("R1 warm", warm_rst_o, 0);
    check("R1 flag", to_flag_o, 0);
    check("R1 reg", reg_rdata, 0);
  endtask

  task automatic t_ratios;
    expect_fire("R2 R9 sel0", BASE, 1'b0);
    expect_fire("R11 restart", BASE, 1'b0);
    write_reg(8'h03);
    expect_fire("R2 sel3", BASE * 8, 1'b0);
    write_reg(8'h07);
    expect_fire("R2 sel7", BASE * 128, 1'b0);
  endtask

  task automatic t_user_bits;
    write_reg(8'hA8);
    expect_fire("R3 user bits", BASE, 1'b0);
    write_reg(8'h00);
  endtask

  task automatic t_single;
    tick_for(200); strobe(0);
    expect_fire("R6 single clears", BASE, 1'b0);
    tick_for(200); strobe(1); strobe(2);
    expect_fire("R6 a/b ignored", BASE - 200, 1'b0);
  endtask

  task automatic t_clear_wins;
    tick_for(BASE - 1);
    osc_tick = 1'b1; instr_tick = 1'b1; clr_single = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0; instr_tick = 1'b0; clr_single = 1'b0;
    check("R12 no pulse", chip_rst_o | warm_rst_o, 0);
    expect_fire("R12 restart", BASE, 1'b0);
  endtask

  task automatic t_dual;
    dual_clr_mode = 1'b1;
    @(negedge clk);
    tick_for(200); strobe(1); strobe(1); strobe(0);
    expect_fire("R7 repeat/single ignored", BASE - 200, 1'b0);
    tick_for(200); strobe(2); tick_for(10); strobe(1);
    expect_fire("R7 b then a", BASE, 1'b0);
    tick_for(200); strobe(3);
    expect_fire("R7 same cycle", BASE, 1'b0);
  endtask

  task automatic t_discard;
    tick_for(100); strobe(1); strobe(4);
    check("R5 halt clears flag", to_flag_o, 0);
    tick_for(100); strobe(2);
    expect_fire("R8 R5 pair discarded", BASE - 100, 1'b0);
    dual_clr_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_halt;
    src_sel = 1'b0; halted = 1'b1;
    strobe(4);
    instr_tick = 1'b1;
    repeat (300) @(negedge clk);
    instr_tick = 1'b0;
    check("R4 instr gated in halt", chip_rst_o | warm_rst_o | to_flag_o, 0);
    src_sel = 1'b1;
    expect_fire("R10 R4 osc in halt", BASE, 1'b1);
    halted = 1'b0; src_sel = 1'b0;
    expect_fire("R4 instr running", BASE, 1'b0);
    src_sel = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ratios;
    t_user_bits;
    t_single;
    t_clear_wins;
    t_dual;
    t_discard;
    t_halt;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule